// File: doc/BRIEF.md
# Zero-Skipping Codebook-Weight MAC Element

This processing element computes one dot product at a time for neural-network inference. Each input beat carries a signed 16-bit activation and a 4-bit weight index. The index selects a 16-bit signed weight from a 16-entry table of shared centroid values. The element multiplies the activation by the selected weight and adds the product into a 40-bit accumulator. Both operands are fixed-point values with 8 fraction bits.

When either the activation or the looked-up weight is zero, the element forces the multiplier's operands to zero and leaves the accumulator untouched. It counts every such skipped element. A beat flagged as last closes the dot product. The element then clamps a negative sum to zero, rescales the sum to the operand format and saturates it. It presents that result on a valid/ready output stream and starts the next dot product from zero.

The weight table is loaded through its own write port. Writes take effect only while no dot product is open.

Top module: `zsw_mac_pe`

## Requirements
- R1: An accepted beat uses the weight stored at table entry `in_widx` (4-bit index, 16 entries, 16-bit signed). A table write accepted while idle is used by every later beat that selects that entry.
- R2: A beat whose activation is zero, or whose selected weight is zero, leaves the accumulated sum unchanged. Each such beat increments `skip_count` by one. `skip_count` is 0 after reset and wraps at 16 bits. Non-zero pairs do not change `skip_count`.
- R3: The accumulator is 40 bits wide and each full 32-bit product is added without truncation. A positive sum above 2^31 therefore stays positive.
- R4: If the accumulated sum is negative when the dot product closes, the output is 0.
- R5: A non-negative sum is shifted right by 8 bits, because a product of two Q8.8 values has 16 fraction bits. The shifted value is output as-is when it is at most 32767, and as 32767 when it is larger.
- R6: The edge that accepts a beat with `in_last`=1 raises `out_valid` with the result, so the result is visible in the next cycle. The accumulator is cleared on that same edge, so the next dot product starts from zero. A last beat that is skipped still closes the dot product.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values and `in_ready` is 0. `out_valid` falls on the edge where `out_ready` is 1.
- R8: A table write is ignored if a dot product is open (at least one beat accepted since the last close) or if a beat is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Element can accept a beat |
| in_act | input | 16 | Signed Q8.8 activation |
| in_widx | input | 4 | Weight table index |
| in_last | input | 1 | Beat closes the dot product |
| cb_we | input | 1 | Weight table write request |
| cb_addr | input | 4 | Weight table write address |
| cb_data | input | 16 | Signed Q8.8 weight to store |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Rectified, saturated Q8.8 result |
| skip_count | output | 16 | Number of skipped elements, wrapping |

## Verification
The skip path and the closing of a dot product can fall in the same cycle when the last beat carries a zero activation or selects a zero weight. The bench provokes this with a last beat of each kind. It judges the outcome by two things: the result must equal the sum of only the earlier non-zero pairs, and `skip_count` must step by one. A second collision, a table write in the middle of an open dot product, is judged by the weight later beats actually use.

// File: rtl/zsw_pkg.sv
`timescale 1ns/1ps
package zsw_pkg;
  localparam int unsigned ZSW_DATA_W = 16;
  localparam int unsigned ZSW_IDX_W  = 4;
  localparam int unsigned ZSW_ACC_W  = 40;
  localparam int unsigned ZSW_FRAC_W = 8;
  localparam int unsigned ZSW_CNT_W  = 16;
endpackage

// File: rtl/zsw_codebook.sv
`timescale 1ns/1ps
module zsw_codebook #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_addr,
  input  logic signed [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]         rd_addr,
  output logic signed [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic signed [DATA_W-1:0] entry_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_addr == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   entry_q[k] <= '0;
      else if (hit) entry_q[k] <= wr_data;
    end
  end

  assign rd_data = entry_q[rd_addr];

  // R1: an entry just written is what a read of that entry returns
  a_r1_written_entry_read: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) && (rd_addr == $past(wr_addr)) |-> rd_data == $past(wr_data));
endmodule

// File: rtl/zsw_mac_acc.sv
`timescale 1ns/1ps
module zsw_mac_acc #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     beat,
  input  logic signed [DATA_W-1:0] act,
  input  logic signed [DATA_W-1:0] wgt,
  input  logic                     last,
  output logic signed [ACC_W-1:0]  sum_o,
  output logic [CNT_W-1:0]         skip_count_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned EXT_W  = ACC_W - PROD_W;

  logic                     skip;
  logic signed [DATA_W-1:0] mul_a, mul_b;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_q, acc_d;
  logic [CNT_W-1:0]         cnt_q, cnt_d;

  assign skip = (act == '0) || (wgt == '0);

  // operand isolation: the multiplier sees zeros on a skipped element
  assign mul_a    = skip ? '0 : act;
  assign mul_b    = skip ? '0 : wgt;
  assign prod     = mul_a * mul_b;
  assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};

  assign sum_o = skip ? acc_q : (acc_q + prod_ext);

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (beat) begin
      acc_d = last ? '0 : sum_o;
      if (skip) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign skip_count_o = cnt_q;

  a_r2_skip_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    beat && skip && !last |=> $stable(acc_q));
  a_r2_skip_counted: assert property (@(posedge clk) disable iff (!rst_n)
    beat && skip |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r2_work_not_counted: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat && skip) |=> $stable(cnt_q));
  a_r6_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    beat && last |=> acc_q == '0);
endmodule

// File: rtl/zsw_relu_out.sv
`timescale 1ns/1ps
module zsw_relu_out #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned FRAC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [ACC_W-1:0] sum_i,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [DATA_W-1:0]       out_data
);
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};

  logic signed [ACC_W-1:0] scaled;
  logic [DATA_W-1:0]       rect;
  logic                    valid_q, valid_d;
  logic [DATA_W-1:0]       data_q, data_d;

  assign scaled = sum_i >>> FRAC_W;

  always_comb begin
    if (sum_i[ACC_W-1])                   rect = '0;
    else if (|scaled[ACC_W-1:DATA_W-1])   rect = POS_MAX;
    else                                  rect = scaled[DATA_W-1:0];
  end

  always_comb begin
    valid_d = valid_q;
    data_d  = data_q;
    if (load) begin
      valid_d = 1'b1;
      data_d  = rect;
    end else if (valid_q && out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  a_r4_out_not_negative: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_data[DATA_W-1]);
  a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r7_drop_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !load |=> !out_valid);
endmodule

// File: rtl/zsw_mac_pe.sv
`timescale 1ns/1ps
module zsw_mac_pe
  import zsw_pkg::*;
#(
  parameter int unsigned DATA_W = ZSW_DATA_W,
  parameter int unsigned IDX_W  = ZSW_IDX_W,
  parameter int unsigned ACC_W  = ZSW_ACC_W,
  parameter int unsigned FRAC_W = ZSW_FRAC_W,
  parameter int unsigned CNT_W  = ZSW_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_act,
  input  logic [IDX_W-1:0]  in_widx,
  input  logic              in_last,
  input  logic              cb_we,
  input  logic [IDX_W-1:0]  cb_addr,
  input  logic [DATA_W-1:0] cb_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  skip_count
);
  logic                     beat;
  logic                     open_q, open_d;
  logic                     cb_commit;
  logic signed [DATA_W-1:0] weight;
  logic signed [ACC_W-1:0]  sum;

  assign in_ready  = !out_valid;
  assign beat      = in_valid && in_ready;
  assign cb_commit = cb_we && !open_q && !beat;

  always_comb begin
    open_d = open_q;
    if (beat) open_d = !in_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  zsw_codebook #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cb_commit),
    .wr_addr (cb_addr),
    .wr_data (cb_data),
    .rd_addr (in_widx),
    .rd_data (weight)
  );

  zsw_mac_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat         (beat),
    .act          (in_act),
    .wgt          (weight),
    .last         (in_last),
    .sum_o        (sum),
    .skip_count_o (skip_count)
  );

  zsw_relu_out #(.DATA_W(DATA_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (beat && in_last),
    .sum_i     (sum),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  a_r6_result_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> out_valid);
  a_r7_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready && in_last) |-> !in_ready);
endmodule

// File: tb/zsw_mac_pe_test.sv
`timescale 1ns/1ps
module zsw_mac_pe_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_last;
  logic [15:0] in_act;
  logic [3:0]  in_widx;
  logic        cb_we;
  logic [3:0]  cb_addr;
  logic [15:0] cb_data;
  logic        out_valid, out_ready;
  logic [15:0] out_data;
  logic [15:0] skip_count;

  int checks = 0;
  int failures = 0;

  logic signed [15:0] cbm [16];
  longint macc = 0;
  int     mskip = 0;

  always #2.5 clk = ~clk;

  zsw_mac_pe uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_act(in_act), .in_widx(in_widx), .in_last(in_last),
    .cb_we(cb_we), .cb_addr(cb_addr), .cb_data(cb_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .skip_count(skip_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint expect_out(input longint acc);
    longint s;
    if (acc < 0) return 0;
    s = acc >>> 8;
    if (s > 32767) return 32767;
    return s;
  endfunction

  task automatic cb_write(input int idx, input int val, input bit taken);
    @(negedge clk);
    cb_we = 1'b1; cb_addr = 4'(idx); cb_data = 16'(val);
    @(negedge clk);
    cb_we = 1'b0;
    if (taken) cbm[idx] = 16'(val);
  endtask

  task automatic send(input int a, input int i, input bit l);
    longint w;
    @(negedge clk);
    in_valid = 1'b1; in_act = 16'(a); in_widx = 4'(i); in_last = l;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    w = longint'(cbm[i]);
    if (a == 0 || w == 0) mskip++;
    else macc += longint'(a) * w;
  endtask

  task automatic take_result(input string req);
    check(out_valid == 1'b1, "R6", {req, " out_valid after last"}, out_valid, 1);
    check(out_data == 16'(expect_out(macc)), req, "out_data",
          out_data, expect_out(macc));
    check(skip_count == 16'(mskip), "R2", {req, " skip_count"}, skip_count, mskip & 16'hffff);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R7", "out_valid drops after take", out_valid, 0);
    macc = 0;
  endtask

  task automatic t_reset;
    check(in_ready == 1'b1, "R7", "reset in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R6", "reset out_valid", out_valid, 0);
    check(skip_count == 16'd0, "R2", "reset skip_count", skip_count, 0);
  endtask

  task automatic t_load_table;
    for (int k = 0; k < 16; k++) begin
      int v;
      case (k)
        0: v = 0;
        1: v = 256;
        2: v = -512;
        3: v = 128;
        4: v = 32767;
        default: v = k * 100 - 700;
      endcase
      cb_write(k, v, 1'b1);
    end
  endtask

  task automatic t_basic;  // R1 R5
    send(1000, 1, 1'b0);
    send(300, 3, 1'b0);
    send(50, 6, 1'b1);
    take_result("R1");
  endtask

  task automatic t_skip;  // R2
    send(0, 5, 1'b0);
    send(400, 0, 1'b0);
    send(640, 3, 1'b0);
    send(0, 0, 1'b0);
    send(200, 9, 1'b1);
    take_result("R2");
  endtask

  task automatic t_negative;  // R4
    send(256, 1, 1'b0);
    send(768, 2, 1'b1);
    check(out_data == 16'd0, "R4", "negative sum clamps", out_data, 0);
    take_result("R4");
  endtask

  task automatic t_saturate;  // R3 R5
    for (int k = 0; k < 4; k++) send(32767, 4, k == 3);
    check(out_data == 16'h7fff, "R3", "wide sum stays positive", out_data, 32767);
    take_result("R5");
  endtask

  task automatic t_skip_on_last;  // R2 R6 same-cycle
    send(2000, 1, 1'b0);
    send(0, 7, 1'b1);
    take_result("R6");
    send(3000, 1, 1'b0);
    send(123, 0, 1'b1);
    take_result("R2");
  endtask

  task automatic t_table_locked;  // R8
    logic signed [15:0] old;
    old = cbm[3];
    send(512, 3, 1'b0);
    cb_write(3, 9999, 1'b0);
    send(512, 3, 1'b1);
    take_result("R8");
    send(1024, 3, 1'b1);
    check(out_data == 16'(expect_out(1024 * longint'(old))), "R8",
          "ignored write left entry", out_data, expect_out(1024 * longint'(old)));
    take_result("R8");
    // write colliding with an accepted beat is ignored too
    @(negedge clk);
    in_valid = 1'b1; in_act = 16'd256; in_widx = 4'd8; in_last = 1'b0;
    cb_we = 1'b1; cb_addr = 4'd8; cb_data = 16'd5000;
    @(negedge clk);
    in_valid = 1'b0; cb_we = 1'b0;
    macc += 256 * longint'(cbm[8]);
    send(256, 8, 1'b1);
    take_result("R8");
  endtask

  task automatic t_idle_write_used;  // R1
    cb_write(10, 1536, 1'b1);
    send(512, 10, 1'b1);
    take_result("R1");
  endtask

  task automatic t_backpressure;  // R7
    logic [15:0] held;
    send(4000, 1, 1'b1);
    held = out_data;
    @(negedge clk);
    in_valid = 1'b1; in_act = 16'd700; in_widx = 4'd1; in_last = 1'b1;
    for (int k = 0; k < 3; k++) begin
      check(out_valid == 1'b1, "R7", "valid held", out_valid, 1);
      check(out_data == held, "R7", "data held", out_data, held);
      check(in_ready == 1'b0, "R7", "input blocked", in_ready, 0);
      @(negedge clk);
    end
    check(held == 16'(expect_out(macc)), "R7", "held value", held, expect_out(macc));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(in_ready == 1'b1, "R7", "input reopens", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    macc = 700 * longint'(cbm[1]);
    take_result("R6");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_act = '0; in_widx = '0; in_last = 1'b0;
    cb_we = 1'b0; cb_addr = '0; cb_data = '0; out_ready = 1'b0;
    for (int k = 0; k < 16; k++) cbm[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_table();
    t_basic();
    t_skip();
    t_negative();
    t_saturate();
    t_skip_on_last();
    t_table_locked();
    t_idle_write_used();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule